// File: doc/BRIEF.md
# Two-Times Streaming Video Upscaler

This block takes a raster pixel stream of a fixed size and emits a stream with twice as many columns and twice as many rows. Each colour channel is scaled on its own. Every new sample is the rounded mean of two existing ones, so the datapath needs only adders and a one-bit shift, with no multiplier or divider. At the right edge of a line and at the bottom of a frame, the outermost input sample is repeated rather than extrapolated.

Two input rows are held on chip. Each output line is built from these stored rows as it is emitted. The upstream side is throttled by a ready signal so that a row is never overwritten while an output line still needs it. The downstream side is a ready/valid stream that marks the start of a frame and the end of each line, so a consumer running at the doubled pixel rate can apply back-pressure freely.

Top module: `video_upscale2x`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `out_valid` is low and `in_ready` is high.
- R2: For each input frame of `IN_W` x `IN_H` pixels, the block emits exactly `2*IN_H` lines of `2*IN_W` pixels. `out_eol` is high only on column `2*IN_W-1`. `out_sof` is high only on column 0 of line 0.
- R3: A pixel carries three 8-bit channels, channel c in bits [8c+7:8c]. On an output line taken from one input row, even column 2i equals input pixel i. Odd column 2i+1, for i < `IN_W-1`, equals (p[i]+p[i+1]+1)>>1, computed per channel with no carry between channels.
- R4: On every line, the last odd column (2*`IN_W`-1) repeats the last input pixel of the row it comes from.
- R5: Output line 2r is the horizontally interpolated form of input row r, following R3 and R4.
- R6: Output line 2r+1, for r < `IN_H-1`, is the per-channel mean (a+b+1)>>1 of the interpolated lines of rows r and r+1.
- R7: The last output line (2*`IN_H`-1) repeats the interpolated form of the last input row.
- R8: When the block is waiting for a new frame, any accepted pixel that does not have `in_sof` set is dropped and has no effect on the output.
- R9: `in_ready` is low whenever the next input row would overwrite a stored row that an output line not yet produced still needs. With the output never drained, the block accepts exactly 2*`IN_W` pixels.
- R10: While `out_valid` is high and `out_ready` is low, `out_pix`, `out_sof` and `out_eol` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel is present |
| in_ready | output | 1 | Block can take an input pixel |
| in_sof | input | 1 | Input pixel is row 0, column 0 of a frame |
| in_pix | input | 24 | Input pixel, three 8-bit channels |
| out_valid | output | 1 | Output pixel is present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_sof | output | 1 | Output pixel starts a frame |
| out_eol | output | 1 | Output pixel ends a line |
| out_pix | output | 24 | Output pixel, three 8-bit channels |

## Verification
The bench runs a small 4x3 configuration through several whole frames and compares every output pixel against an arithmetic model. Each frame uses a different back-pressure pattern, and channel values are chosen so that odd sums exercise the rounding; dropping the +1 would show as an off-by-one on those pixels. An edge sample averaged with a neighbour that does not exist would read stale buffer data in the last column. A bottom line blended with the next frame's first row would mismatch on the final line, and a missed stall would let row 2 overwrite row 0 while line 1 still needs it. Stray pixels are sent ahead of one frame, so a block that counted them would shift that whole frame.

// File: rtl/up2_pkg.sv
package up2_pkg;

    localparam int CHAN_W = 8;
    localparam int NUM_CH = 3;
    localparam int PIX_W  = CHAN_W * NUM_CH;

    typedef logic [CHAN_W-1:0] chan_t;
    typedef logic [PIX_W-1:0]  pix_t;

    // How an output line is formed from the stored rows
    typedef enum logic [1:0] {
        LN_COPY   = 2'd0,   // even line: one row, horizontally interpolated
        LN_BLEND  = 2'd1,   // odd line: mean of two interpolated rows
        LN_REPEAT = 2'd2    // bottom odd line: last row again
    } line_kind_t;

    // Read-side control handed from the sequencer to the datapath
    typedef struct packed {
        logic       odd_col;
        line_kind_t kind;
    } tap_ctl_t;

    // Rounded mean of two channel samples: (a + b + 1) >> 1
    function automatic chan_t chan_avg(input chan_t a, input chan_t b);
        logic [CHAN_W:0] s;
        s = {1'b0, a} + {1'b0, b} + (CHAN_W+1)'(1);
        return s[CHAN_W:1];
    endfunction

endpackage

// File: rtl/up2_line_store.sv
module up2_line_store
    import up2_pkg::*;
#(
    parameter  int W  = 64,
    localparam int AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wsel,
    input  logic [AW-1:0] waddr,
    input  pix_t          wdata,
    input  logic          rsel_a,
    input  logic [AW-1:0] raddr,
    input  logic [AW-1:0] raddr_n,
    output pix_t          a0,
    output pix_t          a1,
    output pix_t          b0,
    output pix_t          b1
);

    // Two row buffers; row r lives in buffer r[0]
    pix_t mem [2][W];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wsel][waddr] <= wdata;
        end
    end

    // Row A is the current source row, row B the one below it
    always_comb begin
        a0 = mem[rsel_a][raddr];
        a1 = mem[rsel_a][raddr_n];
        b0 = mem[~rsel_a][raddr];
        b1 = mem[~rsel_a][raddr_n];
    end

endmodule

// File: rtl/up2_interp.sv
module up2_interp
    import up2_pkg::*;
(
    input  pix_t     a0,
    input  pix_t     a1,
    input  pix_t     b0,
    input  pix_t     b1,
    input  tap_ctl_t ctl,
    output pix_t     pix
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        chan_t ha;
        chan_t hb;
        always_comb begin
            // Horizontal step; at the right edge a1 == a0, so the mean is a0
            ha = ctl.odd_col ? chan_avg(a0[c*CHAN_W +: CHAN_W], a1[c*CHAN_W +: CHAN_W])
                             : a0[c*CHAN_W +: CHAN_W];
            hb = ctl.odd_col ? chan_avg(b0[c*CHAN_W +: CHAN_W], b1[c*CHAN_W +: CHAN_W])
                             : b0[c*CHAN_W +: CHAN_W];
            // Vertical step
            pix[c*CHAN_W +: CHAN_W] = (ctl.kind == LN_BLEND) ? chan_avg(ha, hb) : ha;
        end
    end

endmodule

// File: rtl/up2_seq.sv
module up2_seq
    import up2_pkg::*;
#(
    parameter  int W  = 64,
    parameter  int H  = 48,
    localparam int AW = $clog2(W),
    localparam int RW = $clog2(H + 1),
    localparam int XW = $clog2(2 * W),
    localparam int YW = $clog2(2 * H + 1)
) (
    input  logic          clk,
    input  logic          rst,
    // input side
    input  logic          in_valid,
    input  logic          in_sof,
    output logic          in_ready,
    output logic          we,
    output logic          wsel,
    output logic [AW-1:0] waddr,
    // output side
    input  logic          out_valid,
    input  logic          out_ready,
    output logic          gen,
    output logic          first_px,
    output logic          last_px,
    output logic          rsel_a,
    output logic [AW-1:0] raddr,
    output logic [AW-1:0] raddr_n,
    output tap_ctl_t      ctl
);

    localparam logic [AW-1:0] ICOL_END  = AW'(W - 1);
    localparam logic [RW-1:0] ROWS_ALL  = RW'(H);
    localparam logic [XW-1:0] OCOL_END  = XW'(2 * W - 1);
    localparam logic [YW-1:0] OLINE_ALL = YW'(2 * H);

    logic [AW-1:0] icol;
    logic [RW-1:0] rows_done;   // input rows fully stored this frame
    logic [XW-1:0] ocol;
    logic [YW-1:0] oline;       // output lines fully produced this frame

    logic wait_sof, room, accept, last_row, avail, frame_done, right_edge;
    int   need;

    always_comb begin
        // ---------------- input side ----------------
        wait_sof = (rows_done == '0) && (icol == '0);
        // Row k reuses the buffer of row k-2, last read by line 2k-3
        room     = (int'(rows_done) < 2) ||
                   (int'(oline) >= 2 * int'(rows_done) - 2);
        in_ready = (rows_done != ROWS_ALL) && room;
        accept   = in_valid && in_ready;
        we       = accept && !(wait_sof && !in_sof);
        wsel     = rows_done[0];
        waddr    = icol;

        // ---------------- output side ----------------
        last_row = (int'(oline[YW-1:1]) == H - 1);
        if (!oline[0])      ctl.kind = LN_COPY;
        else if (last_row)  ctl.kind = LN_REPEAT;
        else                ctl.kind = LN_BLEND;
        ctl.odd_col = ocol[0];

        need  = int'(oline[YW-1:1]) + 1 + ((ctl.kind == LN_BLEND) ? 1 : 0);
        avail = (oline != OLINE_ALL) && (int'(rows_done) >= need);
        gen   = avail && (!out_valid || out_ready);

        rsel_a     = oline[1];
        raddr      = ocol[XW-1:1];
        right_edge = (raddr == ICOL_END);
        raddr_n    = right_edge ? raddr : raddr + AW'(1);

        first_px   = (oline == '0) && (ocol == '0);
        last_px    = (ocol == OCOL_END);
        frame_done = (oline == OLINE_ALL) && (rows_done == ROWS_ALL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            icol      <= '0;
            rows_done <= '0;
            ocol      <= '0;
            oline     <= '0;
        end else if (frame_done) begin
            icol      <= '0;
            rows_done <= '0;
            ocol      <= '0;
            oline     <= '0;
        end else begin
            if (we) begin
                if (icol == ICOL_END) begin
                    icol      <= '0;
                    rows_done <= rows_done + RW'(1);
                end else begin
                    icol <= icol + AW'(1);
                end
            end
            if (gen) begin
                if (last_px) begin
                    ocol  <= '0;
                    oline <= oline + YW'(1);
                end else begin
                    ocol <= ocol + XW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/video_upscale2x.sv
module video_upscale2x
    import up2_pkg::*;
#(
    parameter int IN_W = 64,
    parameter int IN_H = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_sof,
    output logic             out_eol,
    output logic [PIX_W-1:0] out_pix
);

    localparam int AW = $clog2(IN_W);

    logic          we, wsel, gen, first_px, last_px, rsel_a;
    logic [AW-1:0] waddr, raddr, raddr_n;
    tap_ctl_t      ctl;
    pix_t          a0, a1, b0, b1, nxt_pix;

    up2_seq #(.W(IN_W), .H(IN_H)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_ready  (in_ready),
        .we        (we),
        .wsel      (wsel),
        .waddr     (waddr),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .gen       (gen),
        .first_px  (first_px),
        .last_px   (last_px),
        .rsel_a    (rsel_a),
        .raddr     (raddr),
        .raddr_n   (raddr_n),
        .ctl       (ctl)
    );

    up2_line_store #(.W(IN_W)) u_store (
        .clk     (clk),
        .we      (we),
        .wsel    (wsel),
        .waddr   (waddr),
        .wdata   (in_pix),
        .rsel_a  (rsel_a),
        .raddr   (raddr),
        .raddr_n (raddr_n),
        .a0      (a0),
        .a1      (a1),
        .b0      (b0),
        .b1      (b1)
    );

    up2_interp u_interp (
        .a0  (a0),
        .a1  (a1),
        .b0  (b0),
        .b1  (b1),
        .ctl (ctl),
        .pix (nxt_pix)
    );

    // Output holding register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
            out_pix   <= '0;
        end else if (gen) begin
            out_valid <= 1'b1;
            out_sof   <= first_px;
            out_eol   <= last_px;
            out_pix   <= nxt_pix;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/video_upscale2x_chk.sv
module video_upscale2x_chk
    import up2_pkg::*;
#(
    parameter  int IN_W = 64,
    localparam int XW   = $clog2(2 * IN_W)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_sof,
    input logic             out_eol,
    input logic [PIX_W-1:0] out_pix
);

    localparam logic [XW-1:0] XLAST = XW'(2 * IN_W - 1);

    logic [XW-1:0] xcnt;
    logic          rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            xcnt <= '0;
        end else if (out_valid && out_ready) begin
            xcnt <= (xcnt == XLAST) ? '0 : xcnt + XW'(1);
        end
    end

    always @(negedge clk) begin
        if (rst_q) begin
            AST_RST_IDLE: assert (!out_valid && in_ready); // R1
        end
    end

    AST_EOL_AT_END: assert property (@(posedge clk) disable iff (rst)
        out_valid && (xcnt == XLAST) |-> out_eol); // R2

    AST_EOL_ONLY_END: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_eol |-> (xcnt == XLAST)); // R2

    AST_SOF_COL_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sof |-> (xcnt == '0)); // R2

    AST_HOLD_PIX: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_pix)); // R10

    AST_HOLD_MARK: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> $stable(out_sof) && $stable(out_eol)); // R10

endmodule

bind video_upscale2x video_upscale2x_chk #(.IN_W(IN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sof   (out_sof),
    .out_eol   (out_eol),
    .out_pix   (out_pix)
);

// File: tb/video_upscale2x_bench.sv
module video_upscale2x_bench;

    localparam int BW = 4;
    localparam int BH = 3;
    localparam int NF = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, in_sof;
    logic [23:0] in_pix;
    logic        out_valid, out_ready, out_sof, out_eol;
    logic [23:0] out_pix;

    int  total = 0;
    int  fails = 0;
    int  accepted = 0;
    int  ptick = 0;
    int  ctick = 0;
    bit  done = 0;
    bit  hold_pending = 0;
    logic [23:0] hold_pix;

    always #10 clk = ~clk;

    video_upscale2x #(.IN_W(BW), .IN_H(BH)) u_video_upscale2x (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_pix(in_pix),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix)
    );

    // ---------------- reference model ----------------
    function automatic int srcv(int fr, int r, int i, int c);
        return (fr * 61 + r * 97 + i * 131 + c * 71 + i * i * 29 + 200 * (i % 2)) % 256;
    endfunction

    function automatic int hval(int fr, int r, int x, int c);
        int i = x / 2;
        if (x % 2 == 0 || i == BW - 1) return srcv(fr, r, i, c);
        return (srcv(fr, r, i, c) + srcv(fr, r, i + 1, c) + 1) / 2;
    endfunction

    function automatic int vval(int fr, int y, int x, int c);
        int r = y / 2;
        if (y % 2 == 0 || r == BH - 1) return hval(fr, r, x, c);
        return (hval(fr, r, x, c) + hval(fr, r + 1, x, c) + 1) / 2;
    endfunction

    function automatic logic [23:0] src_pix(int fr, int r, int i);
        logic [23:0] p;
        for (int c = 0; c < 3; c++) p[c*8 +: 8] = 8'(srcv(fr, r, i, c));
        return p;
    endfunction

    function automatic logic [23:0] exp_pix(int fr, int y, int x);
        logic [23:0] p;
        for (int c = 0; c < 3; c++) p[c*8 +: 8] = 8'(vval(fr, y, x, c));
        return p;
    endfunction

    function automatic string tag_for(int fr, int y, int x);
        if (fr == 1 && y == 0 && x == 0) return "R8";
        if (y % 2 == 1 && y / 2 == BH - 1) return "R7";
        if (y % 2 == 1) return "R6";
        if (x % 2 == 1 && x / 2 == BW - 1) return "R4";
        if (x % 2 == 1) return "R3";
        return "R5";
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- producer ----------------
    task automatic push(logic [23:0] p, logic sof);
        if (ptick % 5 == 3) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        ptick++;
        in_pix   = p;
        in_sof   = sof;
        in_valid = 1'b1;
        forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
        end
        accepted++;
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic send_frame(int fr, bit stray);
        if (stray) begin
            for (int k = 0; k < 3; k++) push(24'hA5C3E1 ^ 24'(k * 7), 1'b0);
        end
        for (int r = 0; r < BH; r++)
            for (int i = 0; i < BW; i++)
                push(src_pix(fr, r, i), (r == 0 && i == 0));
    endtask

    // ---------------- consumer ----------------
    function automatic logic ready_pat(int fr, int t);
        case (fr)
            0: return 1'b1;
            1: return (t % 2) == 0;
            2: return (t % 4) != 0;
            default: return ((t / 3) % 2) == 0;
        endcase
    endfunction

    task automatic take(int fr);
        forever begin
            @(negedge clk);
            out_ready = ready_pat(fr, ctick);
            ctick++;
            #1;
            if (hold_pending && out_valid)
                check(out_pix == hold_pix, "R10", "held pixel", 32'(out_pix), 32'(hold_pix));
            hold_pending = out_valid && !out_ready;
            hold_pix     = out_pix;
            if (out_valid && out_ready) break;
        end
        hold_pending = 0;
    endtask

    // ---------------- main ----------------
    initial begin
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_sof    = 1'b0;
        in_pix    = '0;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!out_valid, "R1", "out_valid after reset", 32'(out_valid), 0);
        check(in_ready, "R1", "in_ready after reset", 32'(in_ready), 1);

        fork
            for (int f = 0; f < NF; f++) send_frame(f, f == 1);
        join_none

        // R9: output never drained, only two rows fit
        repeat (60) @(negedge clk);
        #1;
        check(accepted == 2 * BW, "R9", "pixels accepted while stalled", 32'(accepted), 32'(2 * BW));
        check(!in_ready, "R9", "in_ready while stalled", 32'(in_ready), 0);
        check(out_valid && out_pix == exp_pix(0, 0, 0), "R10", "first pixel held",
              32'(out_pix), 32'(exp_pix(0, 0, 0)));

        for (int f = 0; f < NF; f++)
            for (int y = 0; y < 2 * BH; y++)
                for (int x = 0; x < 2 * BW; x++) begin
                    take(f);
                    check(out_pix == exp_pix(f, y, x), tag_for(f, y, x), "pixel value",
                          32'(out_pix), 32'(exp_pix(f, y, x)));
                    check(out_sof == (x == 0 && y == 0) && out_eol == (x == 2 * BW - 1), "R2",
                          "sof/eol markers", {30'b0, out_sof, out_eol},
                          {30'b0, 1'(x == 0 && y == 0), 1'(x == 2 * BW - 1)});
                end

        @(negedge clk);
        out_ready = 1'b0;
        repeat (20) @(negedge clk);
        #1;
        check(!out_valid, "R2", "no extra output after last frame", 32'(out_valid), 0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule